// File: doc/BRIEF.md
# Protection-Filtered Register Field Array

This block is a 32-bit AXI4-Lite slave that holds an array of identical read-write control fields, for example one small control field per DMA channel. The array is described by parameters. There are `REPEAT` fields of `FIELD_W` bits each. They are packed `PER_REG` at a time into 32-bit registers. Successive registers are `BYTE_STRIDE` bytes apart, starting at `BASE_ADDR`. Within a register, successive fields are `BIT_STRIDE` bits apart, starting at bit `BASE_BIT`. Every field value is also driven onto one flat output vector, so the surrounding logic can use the fields directly.

Each access is filtered by the AXI protection attribute of its own channel. `arprot` is used for reads and `awprot` for writes. There are two six-flag allow masks, one for reads and one for writes. A field register answers only when the flags selected by the three protection bits are all set. A refused access answers SLVERR and changes nothing.

The write side is a five-state machine:

| State | Meaning | Leaves on | Goes to |
|-------|---------|-----------|---------|
| `W_IDLE` | accepts both address and data | both valid | `W_APPLY` |
| | | address only | `W_HAVE_ADDR` |
| | | data only | `W_HAVE_DATA` |
| `W_HAVE_ADDR` | has the address, waits for data | data | `W_APPLY` |
| `W_HAVE_DATA` | has the data, waits for the address | address | `W_APPLY` |
| `W_APPLY` | decodes, checks permission, commits | always | `W_RESP` |
| `W_RESP` | holds the write response | `bready` | `W_IDLE` |

The read side is a three-state machine:

| State | Meaning | Leaves on | Goes to |
|-------|---------|-----------|---------|
| `R_IDLE` | accepts a read address | address | `R_LOOKUP` |
| `R_LOOKUP` | registers the read data and response | always | `R_RESP` |
| `R_RESP` | holds the read response | `rready` | `R_IDLE` |

Top module: `prot_field_bank`

## Requirements
- R1: Field j lives in register r = j / PER_REG, at byte address BASE_ADDR + r*BYTE_STRIDE, in bits starting at BASE_BIT + (j mod PER_REG)*BIT_STRIDE. The last register may hold fewer than PER_REG fields. Address bits [1:0] are ignored.
- R2: `fields_o` carries field j in bits [j*FIELD_W +: FIELD_W], so field 0 is in the least-significant position.
- R3: Protection bit 0 selects unprivileged (0) or privileged (1). Bit 1 selects secure (0) or nonsecure (1). Bit 2 selects data (0) or instruction (1). An allow mask has flag bits [0] unprivileged, [1] privileged, [2] secure, [3] nonsecure, [4] data and [5] instruction. An access is permitted only if all three flags it selects are 1. Reads use `RD_ALLOW` with `arprot`, writes use `WR_ALLOW` with `awprot`, and both masks default to all ones.
- R4: A refused write to a field register answers SLVERR (2'b10) and leaves every field unchanged.
- R5: A refused read of a field register answers SLVERR (2'b10) with read data zero.
- R6: An address that holds no field register answers DECERR (2'b11), whatever the protection. Such a read returns data zero, and such a write changes nothing.
- R7: In a permitted read, register bits that no field covers read as zero.
- R8: A permitted write updates only the field bits whose byte lane has its `wstrb` bit set.
- R9: The write address and write data may be presented together, address first, or data first, and each order completes the write.
- R10: Once `bvalid` or `rvalid` is high, it stays high with stable response and data until the matching ready is seen.
- R11: While `aresetn` is low, all fields are zero and no response is valid.
- R12: The response appears one cycle after its last request handshake: a handshake at rising edge k gives a valid response from edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | clock |
| aresetn | input | 1 | active-low reset |
| awaddr | input | ADDR_W | write address |
| awprot | input | 3 | write protection attribute |
| awvalid | input | 1 | write address valid |
| awready | output | 1 | write address ready |
| wdata | input | 32 | write data |
| wstrb | input | 4 | write byte strobes |
| wvalid | input | 1 | write data valid |
| wready | output | 1 | write data ready |
| bresp | output | 2 | write response |
| bvalid | output | 1 | write response valid |
| bready | input | 1 | write response ready |
| araddr | input | ADDR_W | read address |
| arprot | input | 3 | read protection attribute |
| arvalid | input | 1 | read address valid |
| arready | output | 1 | read address ready |
| rdata | output | 32 | read data |
| rresp | output | 2 | read response |
| rvalid | output | 1 | read response valid |
| rready | input | 1 | read response ready |
| fields_o | output | REPEAT*FIELD_W | all field values, field 0 lowest |

## Verification
A request handshaken at edge k is decoded in the following cycle, and its response is valid from edge k+1. A field write becomes visible on `fields_o` at that same edge. After the last handshake of each access, the bench samples at the next falling edge and expects no response there. It then samples at the falling edge after that and expects the response. The scoreboard compares each response only at a falling edge where valid and ready are both high. Field values on `fields_o` are compared once each write response has been taken.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_HAVE_ADDR,
        W_HAVE_DATA,
        W_APPLY,
        W_RESP
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_LOOKUP,
        R_RESP
    } rd_state_t;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    // allow[0] unpriv, [1] priv, [2] secure, [3] nonsecure, [4] data, [5] instr
    function automatic logic prot_allows(input logic [5:0] allow, input logic [2:0] prot);
        logic lvl_ok;
        logic sec_ok;
        logic kind_ok;
        lvl_ok  = prot[0] ? allow[1] : allow[0];
        sec_ok  = prot[1] ? allow[3] : allow[2];
        kind_ok = prot[2] ? allow[5] : allow[4];
        return lvl_ok & sec_ok & kind_ok;
    endfunction

endpackage

// File: rtl/pfb_decode.sv
module pfb_decode #(
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 0,
    parameter int BYTE_STRIDE = 4,
    parameter int NREG        = 1,
    parameter int IDX_W       = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(BYTE_STRIDE);
    localparam logic [ADDR_W-1:0] NREG_V   = ADDR_W'(NREG);
    localparam logic [ADDR_W-1:0] LANE_MSK = ADDR_W'(3);

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] quot;
    logic [ADDR_W-1:0] remd;

    always_comb begin
        word_addr = addr & ~LANE_MSK;
        offset    = word_addr - BASE_V;
        quot      = offset / STRIDE_V;
        remd      = offset % STRIDE_V;
        hit       = (word_addr >= BASE_V) && (remd == '0) && (quot < NREG_V);
        idx       = quot[IDX_W-1:0];
    end
endmodule

// File: rtl/pfb_field_store.sv
module pfb_field_store #(
    parameter int FIELD_W    = 4,
    parameter int REPEAT     = 7,
    parameter int PER_REG    = 3,
    parameter int BIT_STRIDE = 8,
    parameter int BASE_BIT   = 0,
    parameter int IDX_W      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [31:0]                 wdata,
    input  logic [3:0]                  wstrb,
    input  logic [IDX_W-1:0]            ridx,
    output logic [31:0]                 rword,
    output logic [REPEAT*FIELD_W-1:0]   fields_flat
);
    logic [31:0]        lane_mask;
    logic [31:0]        contrib [REPEAT];

    always_comb begin
        for (int b = 0; b < 32; b++) begin
            lane_mask[b] = wstrb[b/8];
        end
    end

    for (genvar j = 0; j < REPEAT; j++) begin : g_field
        localparam int REG = j / PER_REG;
        localparam int POS = BASE_BIT + (j % PER_REG) * BIT_STRIDE;
        logic [FIELD_W-1:0] value;
        logic [FIELD_W-1:0] bmask;

        assign bmask = lane_mask[POS +: FIELD_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value <= '0;
            end else if (we && (widx == IDX_W'(REG))) begin
                value <= (value & ~bmask) | (wdata[POS +: FIELD_W] & bmask);
            end
        end

        always_comb begin
            contrib[j] = '0;
            contrib[j][POS +: FIELD_W] = value;
        end

        assign fields_flat[j*FIELD_W +: FIELD_W] = value;
    end

    always_comb begin
        rword = '0;
        for (int j = 0; j < REPEAT; j++) begin
            if (ridx == IDX_W'(j / PER_REG)) begin
                rword = rword | contrib[j];
            end
        end
    end
endmodule

// File: rtl/pfb_write_fsm.sv
module pfb_write_fsm
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [2:0]        awprot,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [2:0]        lat_prot,
    output logic [31:0]       lat_data,
    output logic [3:0]        lat_strb,
    input  logic              hit,
    input  logic              allowed,
    output logic              commit
);
    wr_state_t state_q;
    wr_state_t state_d;
    logic [1:0] resp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (awvalid && wvalid) begin
                    state_d = W_APPLY;
                end else if (awvalid) begin
                    state_d = W_HAVE_ADDR;
                end else if (wvalid) begin
                    state_d = W_HAVE_DATA;
                end
            end
            W_HAVE_ADDR: if (wvalid)  state_d = W_APPLY;
            W_HAVE_DATA: if (awvalid) state_d = W_APPLY;
            W_APPLY:                  state_d = W_RESP;
            W_RESP:      if (bready)  state_d = W_IDLE;
            default:                  state_d = W_IDLE;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
            end
            W_HAVE_ADDR: wready  = 1'b1;
            W_HAVE_DATA: awready = 1'b1;
            W_APPLY:     commit  = hit && allowed;
            W_RESP:      bvalid  = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_prot <= '0;
            lat_data <= '0;
            lat_strb <= '0;
            resp_q   <= RESP_OKAY;
        end else begin
            if (awvalid && awready) begin
                lat_addr <= awaddr;
                lat_prot <= awprot;
            end
            if (wvalid && wready) begin
                lat_data <= wdata;
                lat_strb <= wstrb;
            end
            if (state_q == W_APPLY) begin
                resp_q <= !hit ? RESP_DECERR : (!allowed ? RESP_SLVERR : RESP_OKAY);
            end
        end
    end

    assign bresp = resp_q;
endmodule

// File: rtl/pfb_read_fsm.sv
module pfb_read_fsm
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [2:0]        arprot,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [2:0]        lat_prot,
    input  logic              hit,
    input  logic              allowed,
    input  logic [31:0]       word
);
    rd_state_t state_q;
    rd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:   if (arvalid) state_d = R_LOOKUP;
            R_LOOKUP:              state_d = R_RESP;
            R_RESP:   if (rready)  state_d = R_IDLE;
            default:               state_d = R_IDLE;
        endcase
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            R_IDLE:   arready = 1'b1;
            R_RESP:   rvalid  = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_prot <= '0;
            rdata    <= '0;
            rresp    <= RESP_OKAY;
        end else begin
            if (arvalid && arready) begin
                lat_addr <= araddr;
                lat_prot <= arprot;
            end
            if (state_q == R_LOOKUP) begin
                rdata <= (hit && allowed) ? word : '0;
                rresp <= !hit ? RESP_DECERR : (!allowed ? RESP_SLVERR : RESP_OKAY);
            end
        end
    end
endmodule

// File: rtl/prot_field_bank.sv
module prot_field_bank
    import pfb_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         FIELD_W     = 4,
    parameter int         REPEAT      = 7,
    parameter int         PER_REG     = 3,
    parameter int         BYTE_STRIDE = 4,
    parameter int         BIT_STRIDE  = 8,
    parameter int         BASE_ADDR   = 0,
    parameter int         BASE_BIT    = 0,
    parameter logic [5:0] RD_ALLOW    = 6'b111111,
    parameter logic [5:0] WR_ALLOW    = 6'b111111
) (
    input  logic                       aclk,
    input  logic                       aresetn,
    input  logic [ADDR_W-1:0]          awaddr,
    input  logic [2:0]                 awprot,
    input  logic                       awvalid,
    output logic                       awready,
    input  logic [31:0]                wdata,
    input  logic [3:0]                 wstrb,
    input  logic                       wvalid,
    output logic                       wready,
    output logic [1:0]                 bresp,
    output logic                       bvalid,
    input  logic                       bready,
    input  logic [ADDR_W-1:0]          araddr,
    input  logic [2:0]                 arprot,
    input  logic                       arvalid,
    output logic                       arready,
    output logic [31:0]                rdata,
    output logic [1:0]                 rresp,
    output logic                       rvalid,
    input  logic                       rready,
    output logic [REPEAT*FIELD_W-1:0]  fields_o
);
    localparam int NREG  = (REPEAT + PER_REG - 1) / PER_REG;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [ADDR_W-1:0] w_addr;
    logic [2:0]        w_prot;
    logic [31:0]       w_data;
    logic [3:0]        w_strb;
    logic              w_hit;
    logic [IDX_W-1:0]  w_idx;
    logic              w_ok;
    logic              w_commit;

    logic [ADDR_W-1:0] r_addr;
    logic [2:0]        r_prot;
    logic              r_hit;
    logic [IDX_W-1:0]  r_idx;
    logic              r_ok;
    logic [31:0]       r_word;

    assign w_ok = prot_allows(WR_ALLOW, w_prot);
    assign r_ok = prot_allows(RD_ALLOW, r_prot);

    pfb_write_fsm #(.ADDR_W(ADDR_W)) u_wr (
        .clk(aclk), .rst_n(aresetn),
        .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .lat_addr(w_addr), .lat_prot(w_prot), .lat_data(w_data), .lat_strb(w_strb),
        .hit(w_hit), .allowed(w_ok), .commit(w_commit)
    );

    pfb_read_fsm #(.ADDR_W(ADDR_W)) u_rd (
        .clk(aclk), .rst_n(aresetn),
        .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .lat_addr(r_addr), .lat_prot(r_prot),
        .hit(r_hit), .allowed(r_ok), .word(r_word)
    );

    pfb_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BYTE_STRIDE(BYTE_STRIDE),
        .NREG(NREG), .IDX_W(IDX_W)
    ) u_wdec (
        .addr(w_addr), .hit(w_hit), .idx(w_idx)
    );

    pfb_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BYTE_STRIDE(BYTE_STRIDE),
        .NREG(NREG), .IDX_W(IDX_W)
    ) u_rdec (
        .addr(r_addr), .hit(r_hit), .idx(r_idx)
    );

    pfb_field_store #(
        .FIELD_W(FIELD_W), .REPEAT(REPEAT), .PER_REG(PER_REG),
        .BIT_STRIDE(BIT_STRIDE), .BASE_BIT(BASE_BIT), .IDX_W(IDX_W)
    ) u_store (
        .clk(aclk), .rst_n(aresetn),
        .we(w_commit), .widx(w_idx), .wdata(w_data), .wstrb(w_strb),
        .ridx(r_idx), .rword(r_word), .fields_flat(fields_o)
    );
endmodule

// File: rtl/prot_field_bank_chk.sv
module prot_field_bank_chk #(
    parameter int FLAT_W = 28
) (
    input logic              aclk,
    input logic              aresetn,
    input logic              awready,
    input logic              wready,
    input logic [1:0]        bresp,
    input logic              bvalid,
    input logic              bready,
    input logic [31:0]       rdata,
    input logic [1:0]        rresp,
    input logic              rvalid,
    input logic              rready,
    input logic [FLAT_W-1:0] fields_o
);
    // R10
    b_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));

    // R10
    r_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));

    // R4
    fields_quiet_chk: assert property (@(posedge aclk) disable iff (!aresetn)
        !$stable(fields_o) |-> ($rose(bvalid) && bresp == 2'b00));

    // R5
    err_zero_chk: assert property (@(posedge aclk) disable iff (!aresetn)
        (rvalid && rresp != 2'b00) |-> (rdata == '0));

    // R9
    no_accept_in_resp_chk: assert property (@(posedge aclk) disable iff (!aresetn)
        bvalid |-> (!awready && !wready));

    // R11
    always @(posedge aclk) begin
        if (!aresetn) begin
            reset_state_chk: assert (fields_o == '0 && !bvalid && !rvalid);
        end
    end
endmodule

bind prot_field_bank prot_field_bank_chk #(.FLAT_W(REPEAT*FIELD_W)) u_chk (
    .aclk(aclk), .aresetn(aresetn), .awready(awready), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .fields_o(fields_o)
);

// File: tb/prot_field_bank_test.sv
module prot_field_bank_test;
    localparam int NF = 7;

    logic        aclk = 1'b0;
    logic        aresetn = 1'b0;
    logic [7:0]  awaddr = '0;
    logic [2:0]  awprot = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b1;
    logic [7:0]  araddr = '0;
    logic [2:0]  arprot = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b1;
    logic [27:0] fields_o;

    always #5 aclk = ~aclk;

    // fields at 0x10/0x18/0x20, bit 4 + 8*k; reads deny instruction, writes deny unprivileged
    prot_field_bank #(
        .ADDR_W(8), .FIELD_W(4), .REPEAT(7), .PER_REG(3), .BYTE_STRIDE(8),
        .BIT_STRIDE(8), .BASE_ADDR('h10), .BASE_BIT(4),
        .RD_ALLOW(6'b011111), .WR_ALLOW(6'b111110)
    ) uut (.*);

    typedef struct {
        string       tag;
        logic [1:0]  resp;
        logic [31:0] data;
    } exp_t;

    exp_t wq[$];
    exp_t rq[$];
    int   total = 0;
    int   bad = 0;
    logic [3:0] model [NF];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit dec(input logic [7:0] a, output int r);
        int w;
        w = int'(a & 8'hFC);
        r = (w - 'h10) / 8;
        return (w >= 'h10) && (((w - 'h10) % 8) == 0) && (r < 3);
    endfunction

    function automatic logic [31:0] model_word(input int r);
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < 3; k++) begin
            if (r*3 + k < NF) v[4 + 8*k +: 4] = model[r*3 + k];
        end
        return v;
    endfunction

    function automatic logic [27:0] model_flat();
        logic [27:0] v;
        for (int j = 0; j < NF; j++) v[j*4 +: 4] = model[j];
        return v;
    endfunction

    // monitor: compare at handshakes
    always @(negedge aclk) begin
        if (aresetn) begin
            if (bvalid && bready) begin
                if (wq.size() == 0) chk("R9 unexpected write response", 1, 0);
                else begin
                    exp_t e;
                    e = wq.pop_front();
                    chk(e.tag, {62'd0, bresp}, {62'd0, e.resp});
                end
            end
            if (rvalid && rready) begin
                if (rq.size() == 0) chk("R12 unexpected read response", 1, 0);
                else begin
                    exp_t e;
                    e = rq.pop_front();
                    chk(e.tag, {30'd0, rresp, rdata}, {30'd0, e.resp, e.data});
                end
            end
        end
    end

    // order: 0 together, 1 address first, 2 data first
    task automatic do_write(input string tag, input logic [7:0] a, input logic [31:0] d,
                            input logic [3:0] s, input logic [2:0] p, input int order,
                            input int stall);
        int r;
        exp_t e;
        e.tag = tag;
        e.data = '0;
        if (!dec(a, r)) e.resp = 2'b11;
        else if (!p[0]) e.resp = 2'b10;
        else begin
            e.resp = 2'b00;
            for (int k = 0; k < 3; k++) begin
                if (r*3 + k < NF) begin
                    for (int b = 0; b < 4; b++) begin
                        if (s[(4 + 8*k + b) / 8]) model[r*3 + k][b] = d[4 + 8*k + b];
                    end
                end
            end
        end
        wq.push_back(e);
        awaddr = a; awprot = p; wdata = d; wstrb = s;
        awvalid = (order != 2);
        wvalid  = (order != 1);
        if (stall > 0) bready = 1'b0;
        while (awvalid || wvalid) begin
            bit ha;
            bit hw;
            @(negedge aclk);
            ha = awvalid && awready;
            hw = wvalid && wready;
            @(posedge aclk); #1;
            if (ha) awvalid = 1'b0;
            if (hw) wvalid = 1'b0;
            if (order == 1 && ha) wvalid = 1'b1;
            if (order == 2 && hw) awvalid = 1'b1;
        end
        @(negedge aclk);
        chk({"R12 bvalid early ", tag}, bvalid, 0);
        @(negedge aclk);
        chk({"R12 bvalid due ", tag}, bvalid, 1);
        for (int i = 0; i < stall; i++) begin
            @(negedge aclk);
            chk({"R10 bvalid held ", tag}, {62'd0, bvalid, bresp}, {62'd0, 1'b1, e.resp});
        end
        if (stall > 0) begin
            @(posedge aclk); #1;
            bready = 1'b1;
        end
        while (!(bvalid && bready)) @(negedge aclk);
        @(posedge aclk); #1;
        chk({"R2 fields_o after ", tag}, {36'd0, fields_o}, {36'd0, model_flat()});
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input logic [2:0] p);
        int r;
        exp_t e;
        e.tag = tag;
        if (!dec(a, r)) begin e.resp = 2'b11; e.data = '0; end
        else if (p[2]) begin e.resp = 2'b10; e.data = '0; end
        else begin e.resp = 2'b00; e.data = model_word(r); end
        rq.push_back(e);
        araddr = a; arprot = p; arvalid = 1'b1;
        do @(negedge aclk); while (!arready);
        @(posedge aclk); #1;
        arvalid = 1'b0;
        @(negedge aclk);
        chk({"R12 rvalid early ", tag}, rvalid, 0);
        @(negedge aclk);
        chk({"R12 rvalid due ", tag}, rvalid, 1);
        while (!(rvalid && rready)) @(negedge aclk);
        @(posedge aclk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge aclk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < NF; j++) model[j] = '0;
        repeat (3) @(posedge aclk);
        #1;
        chk("R11 reset fields", {36'd0, fields_o}, 64'd0);
        chk("R11 reset valids", {62'd0, bvalid, rvalid}, 64'd0);
        aresetn = 1'b1;
        @(posedge aclk); #1;

        do_read("R11 read after reset", 8'h10, 3'b000);
        do_write("R1 R9 full write together", 8'h10, 32'hFFFF_FFFF, 4'hF, 3'b001, 0, 0);
        do_read("R7 uncovered bits zero", 8'h10, 3'b000);
        do_write("R8 R9 strobe address first", 8'h18, 32'h0000_5A30, 4'b0010, 3'b001, 1, 0);
        do_write("R1 R9 partial reg data first", 8'h20, 32'h0000_0070, 4'b0001, 3'b011, 2, 0);
        do_read("R1 second register", 8'h18, 3'b010);
        do_read("R1 partial last register", 8'h20, 3'b001);
        do_write("R4 unprivileged write refused", 8'h10, 32'h0, 4'hF, 3'b000, 0, 0);
        do_write("R6 write gap address", 8'h14, 32'hFFFF_FFFF, 4'hF, 3'b001, 0, 0);
        do_write("R6 write past end", 8'h28, 32'hFFFF_FFFF, 4'hF, 3'b001, 1, 0);
        do_write("R3 instruction write allowed", 8'h18, 32'h00C0_0B00, 4'hF, 3'b101, 0, 0);
        do_read("R5 R3 instruction read refused", 8'h18, 3'b101);
        do_read("R6 read gap address", 8'h1C, 3'b000);
        do_read("R6 read unprivileged past end", 8'h24, 3'b100);
        do_read("R3 privileged nonsecure read", 8'h18, 3'b011);
        do_write("R10 stalled response", 8'h20, 32'h0000_0030, 4'b0001, 3'b001, 0, 3);
        do_read("R1 R2 final last register", 8'h22, 3'b000);
        chk("R2 flat order", {36'd0, fields_o}, {36'd0, model_flat()});
        chk("R12 all responses seen", wq.size() + rq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule